// File: doc/BRIEF.md
# SDRAM Power-On Mode-Set Sequencer

This block lives inside a memory bus controller. It brings a synchronous DRAM out of power-up. The CPU starts the whole initialization with one word-size write into one of two address windows. The low twelve address bits of that write hold the value that ends up in the SDRAM mode register. The write data is not used.

After it accepts such a write, the sequencer drives the SDRAM command pins itself, with fixed spacing between commands. It first precharges every bank, then issues eight auto-refresh commands, then loads the mode register. The window that was hit selects which of two SDRAM areas gets its chip select. The CPU side sees a one-cycle acknowledge, a busy level for the length of the sequence, and a done flag afterwards.

Typical mode values follow. For a 16-bit part, offsets 0x426/0x446/0x466 give burst-read/single-write and offsets 0x026/0x046/0x066 give burst-read/burst-write, at CAS latency 1/2/3, sequential wrap, burst of 8. For a 32-bit part, the same modes come from offsets 0x848/0x888/0x8C8 and 0x048/0x088/0x0C8, with a burst of 4. The block passes the offset through unchanged.

Top module: `sdram_mrs_seq`

## Requirements
- R1: A write with `cpu_wr` high, `cpu_size` = 2'b01 (word) and `cpu_addr[31:12]` equal to 0xFFFF0 or 0xFFFF8 is a trigger, so the offset is 0x000–0xFFF. The 0xFFFF0xxx window selects area 2 (`sd_cs2_n`) and the 0xFFFF8xxx window selects area 3 (`sd_cs3_n`). Both chip selects are never low together.
- R2: The following writes start nothing and leave the pins deselected: byte size (2'b00), long size (2'b10), size 2'b11, and addresses outside both windows (for example 0xFFFF1426 or 0xFFFE0426).
- R3: `busy` goes high in the cycle after the clock edge that accepts a trigger. `cpu_ack` is high in that same cycle only.
- R4: The command order is fixed: one PALL, then exactly eight REF, then one MRS. PALL is CS low, RAS low, CAS high, WE low, with address bit 10 high. REF is CS, RAS and CAS low, WE high.
- R5: During MRS, CS, RAS, CAS and WE are all low, and `sd_addr` equals the captured offset.
- R6: PALL appears on the pins one cycle after `busy` rises. The first REF follows T_RP cycles after PALL. Each further REF, and the MRS, follows T_RFC cycles after the previous REF. Every cycle in between is a NOP: CS low, RAS, CAS and WE high, address zero.
- R7: Exactly T_MRD cycles after the MRS cycle, `busy` falls and `done` rises. The pins show NOP in that cycle and deselect (all high) from the next cycle on.
- R8: A trigger while `busy` is high is ignored: there is no acknowledge, and the command trace and the MRS address are unchanged.
- R9: `done` stays high while idle. A new trigger clears it in the cycle `busy` rises and reruns the full sequence.
- R10: After reset, `busy`, `done` and `cpu_ack` are low, every command pin is high and `sd_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 2 | Access size: 00 byte, 01 word, 10 long |
| cpu_ack | output | 1 | One-cycle acknowledge of an accepted trigger |
| busy | output | 1 | Initialization in progress |
| done | output | 1 | Initialization completed |
| sd_cs2_n | output | 1 | Chip select, SDRAM area 2, active low |
| sd_cs3_n | output | 1 | Chip select, SDRAM area 3, active low |
| sd_ras_n | output | 1 | Row address strobe, active low |
| sd_cas_n | output | 1 | Column address strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | SDRAM address bus |

## Verification
Take t = 0 as the cycle after the edge that accepts a trigger. At t = 0, `busy` and `cpu_ack` are high and `done` has just cleared. PALL is due at t = 1 because the pins come from a register behind the state machine. REF k (k = 0..7) is due at 1 + T_RP + k·T_RFC, MRS at 1 + T_RP + 8·T_RFC, and `busy` falls and `done` rises T_MRD cycles after MRS. The bench counts cycles from the trigger at falling edges, derives the expected command and status for every cycle from these formulas, and compares the pins on every cycle through deselect. A stray trigger injected mid-sequence must leave every later cycle of that trace unchanged.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
package sdram_init_pkg;

  // CPU access size encoding
  localparam logic [1:0] XFER_BYTE = 2'b00;
  localparam logic [1:0] XFER_WORD = 2'b01;
  localparam logic [1:0] XFER_LONG = 2'b10;

  // Command requested by the sequencer for the next pin cycle
  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_NOP   = 3'd1,
    CMD_PALL  = 3'd2,
    CMD_REF   = 3'd3,
    CMD_MRS   = 3'd4
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PALL     = 3'd1,
    ST_WAIT_RP  = 3'd2,
    ST_REF      = 3'd3,
    ST_WAIT_RFC = 3'd4,
    ST_MRS      = 3'd5,
    ST_WAIT_MRD = 3'd6
  } seq_state_e;

endpackage

// File: rtl/mrs_window_decode.sv
`timescale 1ns/1ps
module mrs_window_decode
  import sdram_init_pkg::*;
#(
  parameter int          CPU_AW    = 32,
  parameter int          MODE_W    = 12,
  parameter logic [31:0] WIN_BASE0 = 32'hFFFF_0000,
  parameter logic [31:0] WIN_BASE1 = 32'hFFFF_8000
) (
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  output logic              hit,
  output logic              area_sel,
  output logic [MODE_W-1:0] mode_val
);

  logic [1:0] win_match;

  // One comparator per window; only the bits above the offset field are compared
  for (genvar gi = 0; gi < 2; gi++) begin : g_win
    localparam logic [31:0] BASE = (gi == 0) ? WIN_BASE0 : WIN_BASE1;
    assign win_match[gi] = (cpu_addr[CPU_AW-1:MODE_W] == BASE[CPU_AW-1:MODE_W]);
  end

  always_comb begin
    hit      = cpu_wr && (cpu_size == XFER_WORD) && (|win_match);
    area_sel = win_match[1];
    mode_val = cpu_addr[MODE_W-1:0];
  end

endmodule

// File: rtl/init_gap_timer.sv
`timescale 1ns/1ps
module init_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/init_cmd_encoder.sv
`timescale 1ns/1ps
module init_cmd_encoder
  import sdram_init_pkg::*;
#(
  parameter int MODE_W = 12,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sd_cmd_e           cmd,
  input  logic              area_sel,
  input  logic [MODE_W-1:0] mode_val,
  output logic              cs2_n,
  output logic              cs3_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [MODE_W-1:0] addr
);

  logic              cs2_d, cs3_d, ras_d, cas_d, we_d;
  logic [MODE_W-1:0] addr_d;
  logic              cs_act;

  always_comb begin
    cs_act = (cmd != CMD_DESEL);
    cs2_d  = !(cs_act && !area_sel);
    cs3_d  = !(cs_act && area_sel);
    ras_d  = 1'b1;
    cas_d  = 1'b1;
    we_d   = 1'b1;
    addr_d = '0;
    case (cmd)
      CMD_PALL: begin
        ras_d  = 1'b0;
        we_d   = 1'b0;
        addr_d = MODE_W'(1) << AP_BIT;
      end
      CMD_REF: begin
        ras_d = 1'b0;
        cas_d = 1'b0;
      end
      CMD_MRS: begin
        ras_d  = 1'b0;
        cas_d  = 1'b0;
        we_d   = 1'b0;
        addr_d = mode_val;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs2_n <= 1'b1;
      cs3_n <= 1'b1;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      addr  <= '0;
    end else begin
      cs2_n <= cs2_d;
      cs3_n <= cs3_d;
      ras_n <= ras_d;
      cas_n <= cas_d;
      we_n  <= we_d;
      addr  <= addr_d;
    end
  end

  // R1: only one area selected at a time
  p_single_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs2_n && !cs3_n));

  // R4: precharge-all carries address bit AP_BIT high
  p_pall_ap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((!cs2_n || !cs3_n) && !ras_n && cas_n && !we_n) |-> addr[AP_BIT]);

endmodule

// File: rtl/sdram_mrs_seq.sv
`timescale 1ns/1ps
module sdram_mrs_seq
  import sdram_init_pkg::*;
#(
  parameter int          CPU_AW    = 32,
  parameter int          MODE_W    = 12,
  parameter logic [31:0] WIN_BASE0 = 32'hFFFF_0000,
  parameter logic [31:0] WIN_BASE1 = 32'hFFFF_8000,
  parameter int          AP_BIT    = 10,
  parameter int          N_REF     = 8,
  parameter int          T_RP      = 3,   // PALL to first REF, >= 2
  parameter int          T_RFC     = 6,   // REF to REF / last REF to MRS, >= 2
  parameter int          T_MRD     = 2    // MRS to done, >= 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  output logic              cpu_ack,
  output logic              busy,
  output logic              done,
  output logic              sd_cs2_n,
  output logic              sd_cs3_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [MODE_W-1:0] sd_addr
);

  localparam int GAP_A   = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int GAP_MAX = (GAP_A > T_MRD) ? GAP_A : T_MRD;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int REF_W   = $clog2(N_REF + 1);
  localparam logic [GAP_W-1:0] RP_LOAD  = GAP_W'(T_RP - 2);
  localparam logic [GAP_W-1:0] RFC_LOAD = GAP_W'(T_RFC - 2);
  localparam logic [GAP_W-1:0] MRD_LOAD = GAP_W'(T_MRD - 1);

  seq_state_e        state_q, state_d;
  logic [REF_W-1:0]  ref_q, ref_d;
  logic [MODE_W-1:0] mode_q;
  logic              area_q;
  logic              done_q, done_d;
  logic              ack_q, ack_d;
  logic              capture;
  logic              ref_en;

  logic              dec_hit, dec_area;
  logic [MODE_W-1:0] dec_mode;
  logic              t_load, t_expired;
  logic [GAP_W-1:0]  t_val;
  sd_cmd_e           cmd;

  mrs_window_decode #(
    .CPU_AW(CPU_AW), .MODE_W(MODE_W),
    .WIN_BASE0(WIN_BASE0), .WIN_BASE1(WIN_BASE1)
  ) u_dec (
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .hit(dec_hit), .area_sel(dec_area), .mode_val(dec_mode)
  );

  init_gap_timer #(.W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .load(t_load), .load_val(t_val), .expired(t_expired)
  );

  init_cmd_encoder #(.MODE_W(MODE_W), .AP_BIT(AP_BIT)) u_enc (
    .clk(clk), .rst_n(rst_n),
    .cmd(cmd), .area_sel(area_q), .mode_val(mode_q),
    .cs2_n(sd_cs2_n), .cs3_n(sd_cs3_n),
    .ras_n(sd_ras_n), .cas_n(sd_cas_n), .we_n(sd_we_n),
    .addr(sd_addr)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    ref_d   = ref_q;
    ref_en  = 1'b0;
    done_d  = done_q;
    ack_d   = 1'b0;
    capture = 1'b0;
    t_load  = 1'b0;
    t_val   = '0;
    cmd     = CMD_NOP;
    case (state_q)
      ST_IDLE: begin
        cmd = CMD_DESEL;
        if (dec_hit) begin
          capture = 1'b1;
          ack_d   = 1'b1;
          done_d  = 1'b0;
          ref_d   = '0;
          ref_en  = 1'b1;
          state_d = ST_PALL;
        end
      end
      ST_PALL: begin
        cmd     = CMD_PALL;
        t_load  = 1'b1;
        t_val   = RP_LOAD;
        state_d = ST_WAIT_RP;
      end
      ST_WAIT_RP: begin
        if (t_expired) state_d = ST_REF;
      end
      ST_REF: begin
        cmd     = CMD_REF;
        t_load  = 1'b1;
        t_val   = RFC_LOAD;
        ref_d   = ref_q + REF_W'(1);
        ref_en  = 1'b1;
        state_d = ST_WAIT_RFC;
      end
      ST_WAIT_RFC: begin
        if (t_expired) state_d = (ref_q == REF_W'(N_REF)) ? ST_MRS : ST_REF;
      end
      ST_MRS: begin
        cmd     = CMD_MRS;
        t_load  = 1'b1;
        t_val   = MRD_LOAD;
        state_d = ST_WAIT_MRD;
      end
      ST_WAIT_MRD: begin
        if (t_expired) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      ack_q   <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= '0;
    else if (ref_en) ref_q <= ref_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      area_q <= 1'b0;
    end else if (capture) begin
      mode_q <= dec_mode;
      area_q <= dec_area;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign cpu_ack = ack_q;

  // R3: acknowledge only accompanies the first busy cycle
  p_ack_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> (busy && $rose(busy)));

  // R8: no acknowledge and no new mode while a sequence runs
  p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (!cpu_ack && $stable(mode_q) && $stable(area_q)));

  // R4: MRS is only reached after all refreshes
  p_ref_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MRS) |-> (ref_q == REF_W'(N_REF)));

  // R6: no command is issued while a gap is still counting
  p_gap_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REF || state_q == ST_MRS) |-> t_expired);

  // R7: done rises exactly when busy falls
  p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  // R5: MRS pins carry the captured mode value
  p_mrs_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((!sd_cs2_n || !sd_cs3_n) && !sd_ras_n && !sd_cas_n && !sd_we_n)
      |-> (sd_addr == mode_q));

endmodule

// File: tb/sdram_mrs_seq_test.sv
`timescale 1ns/1ps
module sdram_mrs_seq_test;

  localparam int TRP   = 3;
  localparam int TRFC  = 6;
  localparam int TMRD  = 2;
  localparam int NREF  = 8;
  localparam int T_MRS = 1 + TRP + NREF * TRFC;

  localparam int C_DESEL = 0, C_NOP = 1, C_PALL = 2, C_REF = 3, C_MRS = 4, C_BAD = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr;
  logic [31:0] cpu_addr;
  logic [1:0]  cpu_size;
  logic        cpu_ack, busy, done;
  logic        sd_cs2_n, sd_cs3_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [11:0] sd_addr;

  int n_vec  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  sdram_mrs_seq #(.N_REF(NREF), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)) uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .cpu_ack(cpu_ack), .busy(busy), .done(done),
    .sd_cs2_n(sd_cs2_n), .sd_cs3_n(sd_cs3_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr)
  );

  task automatic chk(input string req, input string what, input logic ok,
                     input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pin_cmd();
    if (sd_cs2_n && sd_cs3_n) return C_DESEL;
    case ({sd_ras_n, sd_cas_n, sd_we_n})
      3'b111:  return C_NOP;
      3'b010:  return C_PALL;
      3'b001:  return C_REF;
      3'b000:  return C_MRS;
      default: return C_BAD;
    endcase
  endfunction

  function automatic int exp_cmd(input int t);
    if (t == 1) return C_PALL;
    if (t >= 1 + TRP && t < T_MRS && ((t - 1 - TRP) % TRFC) == 0) return C_REF;
    if (t == T_MRS) return C_MRS;
    if (t > 1 && t <= T_MRS + TMRD) return C_NOP;
    return C_DESEL;
  endfunction

  task automatic cpu_write(input logic [31:0] a, input logic [1:0] sz);
    cpu_wr   = 1'b1;
    cpu_addr = a;
    cpu_size = sz;
    @(negedge clk);
    cpu_wr   = 1'b0;
    cpu_addr = '0;
    cpu_size = 2'b00;
  endtask

  task automatic t_reset();
    cpu_wr = 1'b0; cpu_addr = '0; cpu_size = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "busy after reset", busy == 1'b0, busy, 0);
    chk("R10", "done after reset", done == 1'b0, done, 0);
    chk("R10", "ack after reset", cpu_ack == 1'b0, cpu_ack, 0);
    chk("R10", "pins after reset",
        {sd_cs2_n, sd_cs3_n, sd_ras_n, sd_cas_n, sd_we_n} == 5'h1F,
        {sd_cs2_n, sd_cs3_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'h1F);
    chk("R10", "addr after reset", sd_addr == 12'h0, sd_addr, 0);
  endtask

  // Full sequence; optional stray trigger injected mid-run (R8)
  task automatic t_sequence(input logic [31:0] a, input logic inject);
    logic        area3;
    logic [11:0] mode;
    area3 = a[15];
    mode  = a[11:0];
    cpu_write(a, 2'b01);
    // t = 0
    chk("R3", "busy at t0", busy == 1'b1, busy, 1);
    chk("R3", "ack at t0", cpu_ack == 1'b1, cpu_ack, 1);
    chk("R9", "done cleared at t0", done == 1'b0, done, 0);
    for (int t = 1; t <= T_MRS + TMRD + 2; t++) begin
      if (inject && t == 10) begin
        cpu_wr = 1'b1; cpu_addr = 32'hFFFF_0123 ^ {16'h0, area3, 15'h0}; cpu_size = 2'b01;
      end
      @(negedge clk);
      if (inject && t == 10) begin
        cpu_wr = 1'b0; cpu_addr = '0; cpu_size = 2'b00;
      end
      // R4 R6 R7: command trace
      chk(t <= T_MRS ? "R4/R6" : "R7", $sformatf("cmd at t%0d", t),
          pin_cmd() == exp_cmd(t), pin_cmd(), exp_cmd(t));
      if (pin_cmd() != C_DESEL)
        chk("R1", $sformatf("area select t%0d", t),
            area3 ? (!sd_cs3_n && sd_cs2_n) : (!sd_cs2_n && sd_cs3_n),
            {sd_cs2_n, sd_cs3_n}, area3 ? 2'b10 : 2'b01);
      if (exp_cmd(t) == C_MRS)
        chk("R5", "MRS address", sd_addr == mode, sd_addr, mode);
      if (exp_cmd(t) == C_PALL)
        chk("R4", "PALL A10", sd_addr[10] == 1'b1, sd_addr[10], 1);
      if (exp_cmd(t) == C_NOP)
        chk("R6", "NOP address", sd_addr == 12'h0, sd_addr, 0);
      chk("R7", $sformatf("busy t%0d", t), busy == (t < T_MRS + TMRD),
          busy, (t < T_MRS + TMRD));
      chk("R7", $sformatf("done t%0d", t), done == (t >= T_MRS + TMRD),
          done, (t >= T_MRS + TMRD));
      chk(inject ? "R8" : "R3", $sformatf("no ack t%0d", t), cpu_ack == 1'b0, cpu_ack, 0);
    end
  endtask

  task automatic t_no_trigger(input logic [31:0] a, input logic [1:0] sz, input string why);
    logic d0;
    d0 = done;
    cpu_write(a, sz);
    for (int t = 0; t < 5; t++) begin
      chk("R2", {why, " busy"}, busy == 1'b0, busy, 0);
      chk("R2", {why, " ack"}, cpu_ack == 1'b0, cpu_ack, 0);
      chk("R2", {why, " pins"}, pin_cmd() == C_DESEL, pin_cmd(), C_DESEL);
      chk("R9", {why, " done kept"}, done == d0, done, d0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_no_trigger(32'hFFFF_0426, 2'b00, "byte size");
    t_no_trigger(32'hFFFF_8848, 2'b10, "long size");
    t_no_trigger(32'hFFFF_0446, 2'b11, "size 11");
    t_no_trigger(32'hFFFF_1426, 2'b01, "offset out of range");
    t_no_trigger(32'hFFFE_0426, 2'b01, "other region");
    t_sequence(32'hFFFF_0426, 1'b0);   // area 2, 16-bit single-write CL1
    t_no_trigger(32'hFFFF_9000, 2'b01, "above high window");
    t_sequence(32'hFFFF_88C8, 1'b1);   // area 3, stray trigger mid-run
    t_sequence(32'hFFFF_0066, 1'b0);   // rerun after done
    t_sequence(32'hFFFF_8FFF, 1'b0);   // top of offset range
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule